// File: doc/BRIEF.md
# Two-wire bus condition detector

This block sits between the raw clock and data lines of a two-wire serial bus and the protocol engine that decodes it. Both lines are sampled by a fast system clock, passed through a two-flop synchroniser each, and then through a counter-based spike filter. The filter accepts a new level only after the synchronised input has differed from the current filtered level for more than `filt_len` consecutive system clocks. Any pulse of `filt_len` cycles or fewer is discarded. At a 250 MHz system clock, a setting of 13 removes spikes of 50 ns.

From the filtered levels, the block derives four single-cycle strobes. A start strobe fires when data falls while the clock line is high, and a stop strobe fires when data rises while the clock line is high. A clock-rise strobe marks the data sample point, and a clock-fall strobe marks the point where data may change. A bus-idle flag is set by a stop and cleared by a start. The filtered levels themselves are also brought out.

Top module: `twb_cond_detect`

## Requirements
- R1: While reset is active and directly after it, all four strobes are 0, both filtered levels are 1 and `bus_idle` is 1.
- R2: A pulse on either raw line lasting `filt_len` system clocks or fewer changes neither filtered level and raises no strobe.
- R3: A raw level held for at least `filt_len`+1 clocks is accepted. If the change is first sampled at rising edge k, the filtered level changes at edge k+2+`filt_len` and the resulting strobe shows at edge k+3+`filt_len`.
- R4: `start_stb` pulses when filtered data goes 1 to 0 in a cycle where filtered clock is 1.
- R5: `stop_stb` pulses when filtered data goes 0 to 1 in a cycle where filtered clock is 1. A start and a stop never pulse together.
- R6: `scl_rise_stb` pulses on each filtered clock 0 to 1 transition, and `scl_fall_stb` pulses on each 1 to 0 transition. These two never pulse together.
- R7: A data change while filtered clock is 0 gives neither a start nor a stop.
- R8: `bus_idle` becomes 0 in the cycle the start strobe shows and 1 in the cycle the stop strobe shows. No other event changes it.
- R9: The clock level used for start and stop is the one from the same cycle as the data change. A data fall coinciding with a clock rise gives start plus clock-rise. A data rise coinciding with a clock rise gives stop plus clock-rise. A data change coinciding with a clock fall gives clock-fall only.
- R10: Every strobe lasts exactly one system clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_raw | input | 1 | Raw serial clock line sample |
| sda_raw | input | 1 | Raw serial data line sample |
| filt_len | input | CNT_W | Longest rejected pulse, in system clocks |
| scl_lvl | output | 1 | Filtered clock level |
| sda_lvl | output | 1 | Filtered data level |
| bus_idle | output | 1 | 1 between a stop and the next start |
| start_stb | output | 1 | Start condition strobe |
| stop_stb | output | 1 | Stop condition strobe |
| scl_rise_stb | output | 1 | Filtered clock rising edge strobe |
| scl_fall_stb | output | 1 | Filtered clock falling edge strobe |

## Verification
Two functions can land in the same cycle: a start or stop, and a clock edge. This happens when both raw lines are switched on the same clock, so that both pass the synchronisers and filters in step. The bench drives data-fall together with clock-rise, data-rise together with clock-rise, and data-fall together with clock-fall. It expects one combined strobe mask per case, with the start/stop bit set only when the clock level of that same cycle is high. The scoreboard compares the whole mask and the idle flag at the moment any strobe appears, so a missing half or an extra half of a coincident pair is reported.

// File: rtl/twb_pkg.sv
package twb_pkg;
  typedef struct packed {
    logic start;
    logic stop;
    logic scl_rise;
    logic scl_fall;
  } twb_ev_t;

  localparam int unsigned LINE_SCL  = 0;
  localparam int unsigned LINE_SDA  = 1;
  localparam int unsigned NUM_LINES = 2;
endpackage

// File: rtl/twb_rst_sync.sv
module twb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/twb_sync.sv
module twb_sync #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
    end
  end

  assign dout = sync_q;
endmodule

// File: rtl/twb_glitch_filter.sv
module twb_glitch_filter #(
  parameter int unsigned CNT_W   = 5,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  input  logic [CNT_W-1:0] len,
  output logic             dout
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             lvl_q, lvl_d;
  logic             differs;

  assign differs = (din != lvl_q);

  always_comb begin
    cnt_d = '0;
    lvl_d = lvl_q;
    if (differs) begin
      if (cnt_q == len) begin
        lvl_d = din;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= RST_VAL;
    end else begin
      cnt_q <= cnt_d;
      lvl_q <= lvl_d;
    end
  end

  assign dout = lvl_q;

  // R3: an accepted level always equals the input seen one cycle before
  a_r3_accept_source: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lvl_q) |-> (lvl_q == $past(din)));
endmodule

// File: rtl/twb_event_gen.sv
module twb_event_gen
  import twb_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    scl_f,
  input  logic    sda_f,
  output twb_ev_t ev,
  output logic    idle
);
  logic    scl_d_q, sda_d_q;
  twb_ev_t ev_q, ev_d;
  logic    idle_q, idle_d;

  always_comb begin
    ev_d.start    = sda_d_q & ~sda_f & scl_f;
    ev_d.stop     = ~sda_d_q & sda_f & scl_f;
    ev_d.scl_rise = ~scl_d_q & scl_f;
    ev_d.scl_fall = scl_d_q & ~scl_f;
    idle_d        = idle_q;
    if (ev_d.stop)       idle_d = 1'b1;
    else if (ev_d.start) idle_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d_q <= 1'b1;
      sda_d_q <= 1'b1;
      ev_q    <= '0;
      idle_q  <= 1'b1;
    end else begin
      scl_d_q <= scl_f;
      sda_d_q <= sda_f;
      ev_q    <= ev_d;
      idle_q  <= idle_d;
    end
  end

  assign ev   = ev_q;
  assign idle = idle_q;

  a_r8_start_clears_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ev_q.start |-> !idle_q);
  a_r8_stop_sets_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ev_q.stop |-> idle_q);
  a_r5_start_stop_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_q.start, ev_q.stop}));
  a_r6_edges_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_q.scl_rise, ev_q.scl_fall}));
  a_r7_condition_needs_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_q.start || ev_q.stop) |-> $past(scl_f));
  a_r10_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    ev_q.start |=> !ev_q.start);
  a_r10_stop_single: assert property (@(posedge clk) disable iff (!rst_n)
    ev_q.stop |=> !ev_q.stop);
endmodule

// File: rtl/twb_cond_detect.sv
module twb_cond_detect
  import twb_pkg::*;
#(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_raw,
  input  logic             sda_raw,
  input  logic [CNT_W-1:0] filt_len,
  output logic             scl_lvl,
  output logic             sda_lvl,
  output logic             bus_idle,
  output logic             start_stb,
  output logic             stop_stb,
  output logic             scl_rise_stb,
  output logic             scl_fall_stb
);
  logic                 rst_s_n;
  logic [NUM_LINES-1:0] raw_vec, sync_vec, filt_vec;
  twb_ev_t              ev;

  twb_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_s_n)
  );

  assign raw_vec[LINE_SCL] = scl_raw;
  assign raw_vec[LINE_SDA] = sda_raw;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    twb_sync #(.RST_VAL(1'b1)) u_sync (
      .clk  (clk),
      .rst_n(rst_s_n),
      .din  (raw_vec[i]),
      .dout (sync_vec[i])
    );
    twb_glitch_filter #(.CNT_W(CNT_W), .RST_VAL(1'b1)) u_filt (
      .clk  (clk),
      .rst_n(rst_s_n),
      .din  (sync_vec[i]),
      .len  (filt_len),
      .dout (filt_vec[i])
    );
  end

  twb_event_gen u_ev (
    .clk  (clk),
    .rst_n(rst_s_n),
    .scl_f(filt_vec[LINE_SCL]),
    .sda_f(filt_vec[LINE_SDA]),
    .ev   (ev),
    .idle (bus_idle)
  );

  assign scl_lvl      = filt_vec[LINE_SCL];
  assign sda_lvl      = filt_vec[LINE_SDA];
  assign start_stb    = ev.start;
  assign stop_stb     = ev.stop;
  assign scl_rise_stb = ev.scl_rise;
  assign scl_fall_stb = ev.scl_fall;
endmodule

// File: tb/tb_twb_cond_detect.sv
module tb_twb_cond_detect;
  localparam int CNT_W = 5;
  localparam logic [3:0] M_START = 4'b1000, M_STOP = 4'b0100,
                         M_RISE  = 4'b0010, M_FALL = 4'b0001;

  logic clk = 1'b0, rst_n = 1'b0, scl_raw = 1'b1, sda_raw = 1'b1;
  logic [CNT_W-1:0] filt_len = '0;
  logic scl_lvl, sda_lvl, bus_idle, start_stb, stop_stb, scl_rise_stb, scl_fall_stb;

  typedef struct { logic [3:0] mask; logic idle; string tag; } exp_t;
  exp_t q[$];
  int checks = 0, fails = 0, n_len = 0, hold = 4;
  bit live = 1'b0;

  always #2 clk = ~clk;

  twb_cond_detect #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .scl_raw(scl_raw), .sda_raw(sda_raw), .filt_len(filt_len),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .bus_idle(bus_idle), .start_stb(start_stb),
    .stop_stb(stop_stb), .scl_rise_stb(scl_rise_stb), .scl_fall_stb(scl_fall_stb));

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (filt_len %0d)", tag, act, exp, n_len);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // monitor: pops one expected item per observed strobe cycle
  always @(negedge clk) begin
    logic [3:0] got;
    got = {start_stb, stop_stb, scl_rise_stb, scl_fall_stb};
    if (live && got != 4'b0) begin
      if (q.size() == 0) begin
        check(1'b0, "unexpected strobe R2 R7", {3'b0, bus_idle, got}, 8'h00);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(got == e.mask && bus_idle == e.idle, e.tag, {3'b0, bus_idle, got}, {3'b0, e.idle, e.mask});
      end
    end
  end

  task automatic push(input logic [3:0] m, input logic idl, input string tag);
    exp_t e;
    e.mask = m; e.idle = idl; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic drive(input logic c, input logic d, input logic [3:0] m, input logic idl, input string tag);
    @(negedge clk);
    scl_raw = c; sda_raw = d;
    if (m != 4'b0) push(m, idl, tag);
    repeat (hold) @(negedge clk);
  endtask

  // a pulse of w clocks against a high line; accepted when w > filt_len
  task automatic pulse(input bit on_sda, input int w);
    bit pass, stay;
    pass = (w > n_len);
    stay = 1'b1;
    @(negedge clk);
    if (on_sda) sda_raw = 1'b0; else scl_raw = 1'b0;
    if (pass) begin
      if (on_sda) push(M_START, 1'b0, "R3 R4 accepted sda pulse start");
      else        push(M_FALL, 1'b1, "R3 R6 accepted scl pulse fall");
    end
    repeat (w) @(negedge clk);
    if (on_sda) sda_raw = 1'b1; else scl_raw = 1'b1;
    if (pass) begin
      if (on_sda) push(M_STOP, 1'b1, "R3 R5 accepted sda pulse stop");
      else        push(M_RISE, 1'b1, "R3 R6 accepted scl pulse rise");
    end
    for (int i = 0; i < hold + w; i++) begin
      @(negedge clk);
      if (!(scl_lvl && sda_lvl)) stay = 1'b0;
    end
    if (!pass) check(stay, "R2 short pulse left levels high", {7'b0, stay}, 8'h01);
  endtask

  task automatic do_reset(input int len);
    live = 1'b0;
    n_len = len; hold = len + 6;
    filt_len = CNT_W'(len);
    scl_raw = 1'b1; sda_raw = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check({start_stb, stop_stb, scl_rise_stb, scl_fall_stb} == 4'b0 && scl_lvl && sda_lvl && bus_idle,
          "R1 state in reset", {1'b0, scl_lvl, sda_lvl, bus_idle, start_stb, stop_stb, scl_rise_stb, scl_fall_stb}, 8'h70);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check({start_stb, stop_stb, scl_rise_stb, scl_fall_stb} == 4'b0 && scl_lvl && sda_lvl && bus_idle,
          "R1 state after reset", {1'b0, scl_lvl, sda_lvl, bus_idle, start_stb, stop_stb, scl_rise_stb, scl_fall_stb}, 8'h70);
    live = 1'b1;
  endtask

  task automatic run_config(input int len);
    int n;
    do_reset(len);
    // R3 latency of the filtered data level
    @(negedge clk);
    sda_raw = 1'b0;
    push(M_START, 1'b0, "R3 R4 start after latency");
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (sda_lvl !== 1'b0 && n < 100);
    check(n == len + 3, "R3 filtered level latency", 8'(n), 8'(len + 3));
    repeat (hold) @(negedge clk);
    drive(1, 1, M_STOP, 1'b1, "R5 R8 stop sets idle");
    // plain transfer shape
    drive(1, 0, M_START, 1'b0, "R4 R8 start clears idle");
    drive(0, 0, M_FALL, 1'b0, "R6 scl fall");
    drive(0, 1, 4'b0, 1'b0, "R7");
    drive(1, 1, M_RISE, 1'b0, "R6 R7 scl rise, no stop from low-phase change");
    drive(0, 1, M_FALL, 1'b0, "R6 scl fall");
    drive(0, 0, 4'b0, 1'b0, "R7");
    drive(1, 0, M_RISE, 1'b0, "R6 R7 scl rise, no start from low-phase change");
    drive(1, 1, M_STOP, 1'b1, "R5 R8 stop");
    // coincident changes
    drive(0, 1, M_FALL, 1'b1, "R6 R8 fall keeps idle");
    drive(1, 0, M_START | M_RISE, 1'b0, "R9 start with scl rise");
    drive(0, 0, M_FALL, 1'b0, "R6 fall");
    drive(1, 1, M_STOP | M_RISE, 1'b1, "R9 stop with scl rise");
    drive(0, 0, M_FALL, 1'b1, "R9 sda fall with scl fall is no start");
    drive(1, 1, M_STOP | M_RISE, 1'b1, "R9 stop with scl rise from low");
    // spike filtering at the boundary
    if (len > 0) begin
      pulse(1'b1, len);
      pulse(1'b0, len);
      if (len > 1) pulse(1'b1, 1);
    end
    pulse(1'b1, len + 1);
    pulse(1'b0, len + 1);
    repeat (hold) @(negedge clk);
    check(q.size() == 0, "R10 all expected strobes seen", 8'(q.size()), 8'h00);
    q.delete();
  endtask

  initial begin
    run_config(13);
    run_config(3);
    run_config(0);
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end
endmodule